// File: doc/BRIEF.md
# TMDS Lane Encoder and Bit Serializer

This block drives one lane of a DVI or HDMI style video link. Once per pixel period it takes an 8-bit colour value, a data-enable flag and two control bits, and turns them into a 10-bit symbol. In active video the symbol first has its transitions reduced. A running disparity count then decides whether the low byte is sent inverted, so that ones and zeros stay balanced over the long run. In blanking one of four fixed control symbols is sent and the count is cleared.

A parallel-load shift register sends each symbol out least-significant bit first. It moves one bit per cycle of the bit-rate strobe `bit_en`, so a pixel period is ten strobes long. The block runs on a single clock at or above the bit rate and produces its own pixel timing. `pix_take` marks the strobe edge at which the pixel inputs are sampled. A per-pixel repeat flag sends a pixel as two consecutive symbols, which lets slow video modes stay above the link's minimum pixel rate of 25 MHz (250 Mbit/s per lane).

Top module: `tmds_lane`

## Requirements
- R1: After a synchronous reset, `ser_out` and `pix_take` are 0 and the disparity count is zero. The first `bit_en` strobe after reset loads and starts sending the control symbol 0x354.
- R2: A pixel taken with `pix_de` low is sent as control symbol 0x354, 0x0AB, 0x154 or 0x2AB for `pix_ctl` = 0, 1, 2 or 3. `pix_data` has no effect on that symbol, and the disparity count is cleared to zero.
- R3: For data, stage one counts the ones in the byte. It chains with XNOR when the count is above four, or exactly four with bit 0 clear, and with XOR otherwise. Bit 0 passes straight through, and intermediate bit 8 is 1 for XOR and 0 for XNOR.
- R4: Stage two applies three rules. (1) If the count is zero or the intermediate low byte is balanced, symbol bit 9 is the inverse of intermediate bit 8, and the low byte is inverted only when bit 8 is 0. (2) Otherwise, if the count and the byte's excess of ones over zeros have the same sign, the low byte is inverted and bit 9 is set. (3) Otherwise the low byte is kept and bit 9 is clear. Symbol bit 8 always equals intermediate bit 8.
- R5: The encodings are fixed, written as byte: positive / zero / negative count. 0x00: 0x100/0x100/0x3FF. 0x10: 0x1F0 in all three. 0x1F: 0x2A0/0x2A0/0x05F. 0xFF: 0x200/0x200/0x0FF. Over all bytes and all three sign cases there are 460 distinct symbols: 204 bytes have exactly two equal variants and 52 bytes have three equal variants.
- R6: Sum the ones-minus-zeros of every data symbol sent since the last control symbol. This sum is even after each symbol and stays within -8 to +8.
- R7: Each `bit_en` strobe advances `ser_out` by one bit, bit 0 of the symbol first. The strobe after the tenth bit starts the next symbol with no gap. Without a strobe `ser_out` does not change.
- R8: `pix_take` is high only in a strobe cycle that loads a new symbol, which is strobe 0, 10, 20 and so on counted from reset. The pixel on the inputs at that edge becomes the next symbol sent.
- R9: A pixel taken with `pix_rep` high is sent as two consecutive symbols, the second encoded again against the updated disparity count. No pixel is taken at the load that starts the second copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-rate strobe; one serial bit per high cycle |
| pix_data | input | 8 | Colour value for this lane |
| pix_de | input | 1 | High for active video, low for blanking |
| pix_ctl | input | 2 | Control code sent while `pix_de` is low |
| pix_rep | input | 1 | Send this pixel twice |
| pix_take | output | 1 | Pixel inputs are sampled at this clock edge |
| ser_out | output | 1 | Serial symbol stream, LSB first |

## Verification
The assertions check on every cycle that the disparity count stays even and bounded, that blanking clears it, and that the encoder and shift register hold their state while not strobed. Only the bench scenarios can show the per-byte symbol choice and the reference encodings. The bench sweeps every byte against each of the three count signs, reached through a control symbol followed by a biasing byte, and counts the distinct symbols seen. Gap-free serial framing, the load cycle of `pix_take`, and re-encoding on repeat are also shown only by the bench, which rebuilds the serial stream under a steady strobe and under a sparse one.

// File: rtl/tmds_lane_pkg.sv
package tmds_lane_pkg;

  localparam int BYTE_W = 8;
  localparam int SYM_W  = 10;

  // blanking symbols, indexed by the two control bits
  localparam logic [SYM_W-1:0] CTL_SYM [4] = '{10'h354, 10'h0AB, 10'h154, 10'h2AB};

  typedef struct packed {
    logic              de;
    logic [1:0]        ctl;
    logic [BYTE_W-1:0] data;
  } pixel_t;

  function automatic logic [3:0] pop8(input logic [BYTE_W-1:0] v);
    logic [3:0] s;
    s = '0;
    for (int i = 0; i < BYTE_W; i++) s = s + {3'b000, v[i]};
    return s;
  endfunction

endpackage

// File: rtl/tmds_minimise.sv
// Stage one: transition reduction (R3)
module tmds_minimise
  import tmds_lane_pkg::*;
(
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W:0]   qm
);

  logic [3:0] n1;
  logic       use_xnor;

  assign n1       = pop8(din);
  assign use_xnor = (n1 > 4'd4) || ((n1 == 4'd4) && !din[0]);

  always_comb begin
    logic acc;
    acc   = din[0];
    qm[0] = acc;
    for (int i = 1; i < BYTE_W; i++) begin
      acc   = use_xnor ? ~(acc ^ din[i]) : (acc ^ din[i]);
      qm[i] = acc;
    end
    qm[BYTE_W] = ~use_xnor;
  end

endmodule

// File: rtl/tmds_balance.sv
// Stage two: DC balance and running disparity (R2, R4, R6)
module tmds_balance
  import tmds_lane_pkg::*;
#(
  parameter int DISP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             de,
  input  logic [1:0]       ctl,
  input  logic [BYTE_W:0]  qm,
  output logic [SYM_W-1:0] sym_q
);

  localparam logic signed [DISP_W-1:0] ZERO = '0;
  localparam logic signed [DISP_W-1:0] TWO  = DISP_W'(2);
  localparam logic signed [DISP_W-1:0] LIM  = DISP_W'(BYTE_W);

  logic signed [DISP_W-1:0] disp_q, nxt_disp, n1s, bal;
  logic        [SYM_W-1:0]  nxt_sym;
  logic                     q8;

  assign q8  = qm[BYTE_W];
  assign n1s = $signed(DISP_W'(pop8(qm[BYTE_W-1:0])));
  assign bal = (n1s + n1s) - LIM;  // ones minus zeros of the low byte

  always_comb begin
    if (!de) begin
      nxt_sym  = CTL_SYM[ctl];
      nxt_disp = ZERO;
    end else if (disp_q == ZERO || bal == ZERO) begin
      nxt_sym  = {~q8, q8, q8 ? qm[BYTE_W-1:0] : ~qm[BYTE_W-1:0]};
      nxt_disp = q8 ? disp_q + bal : disp_q - bal;
    end else if ((disp_q > ZERO) == (bal > ZERO)) begin
      nxt_sym  = {1'b1, q8, ~qm[BYTE_W-1:0]};
      nxt_disp = disp_q - bal + (q8 ? TWO : ZERO);
    end else begin
      nxt_sym  = {1'b0, q8, qm[BYTE_W-1:0]};
      nxt_disp = disp_q + bal - (q8 ? ZERO : TWO);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_q  <= CTL_SYM[0];
      disp_q <= ZERO;
    end else if (en) begin
      sym_q  <= nxt_sym;
      disp_q <= nxt_disp;
    end
  end

  p_disp_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (disp_q <= LIM) && (disp_q >= -LIM));

  p_disp_even_r6: assert property (@(posedge clk) disable iff (rst)
    !disp_q[0]);

  p_ctl_clear_r2: assert property (@(posedge clk) disable iff (rst)
    en && !de |=> disp_q == ZERO);

  p_enc_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(sym_q) && $stable(disp_q));

endmodule

// File: rtl/tmds_shift.sv
// Parallel-load serializer, LSB first (R7)
module tmds_shift #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_en,
  input  logic [W-1:0] sym_in,
  output logic         load,
  output logic         ser_out
);

  localparam int             CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     sh;
  logic [CNT_W-1:0] cnt;

  assign load    = bit_en && (cnt == LAST);
  assign ser_out = sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      cnt <= LAST;
    end else if (bit_en) begin
      if (cnt == LAST) begin
        sh  <= sym_in;
        cnt <= '0;
      end else begin
        sh  <= {1'b0, sh[W-1:1]};
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_cnt_range_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  p_shift_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(sh) && $stable(cnt));

endmodule

// File: rtl/tmds_lane.sv
module tmds_lane
  import tmds_lane_pkg::*;
#(
  parameter int DISP_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic [BYTE_W-1:0] pix_data,
  input  logic              pix_de,
  input  logic [1:0]        pix_ctl,
  input  logic              pix_rep,
  output logic              pix_take,
  output logic              ser_out
);

  pixel_t             live, held, cur;
  logic               load, hold_q;
  logic [BYTE_W:0]    qm;
  logic [SYM_W-1:0]   sym;

  assign live     = {pix_de, pix_ctl, pix_data};
  // a repeat load re-encodes the stored pixel instead of sampling the ports (R9)
  assign pix_take = load && !hold_q && !rst;
  assign cur      = pix_take ? live : held;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      held   <= '0;
    end else if (load) begin
      if (hold_q) begin
        hold_q <= 1'b0;
      end else begin
        hold_q <= pix_rep;
        held   <= live;
      end
    end
  end

  tmds_minimise u_min (
    .din (cur.data),
    .qm  (qm)
  );

  tmds_balance #(.DISP_W(DISP_W)) u_bal (
    .clk   (clk),
    .rst   (rst),
    .en    (load),
    .de    (cur.de),
    .ctl   (cur.ctl),
    .qm    (qm),
    .sym_q (sym)
  );

  tmds_shift #(.W(SYM_W)) u_ser (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .sym_in  (sym),
    .load    (load),
    .ser_out (ser_out)
  );

endmodule

// File: tb/sim_tmds_lane.sv
module sim_tmds_lane;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic [7:0] pix_data = 8'h00;
  logic       pix_de = 1'b0;
  logic [1:0] pix_ctl = 2'b00;
  logic       pix_rep = 1'b0;
  logic       pix_take, ser_out;

  always #5 clk = ~clk;

  tmds_lane u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .pix_data(pix_data), .pix_de(pix_de),
    .pix_ctl(pix_ctl), .pix_rep(pix_rep), .pix_take(pix_take), .ser_out(ser_out)
  );

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // expected symbol queue
  localparam int QN = 4096;
  logic [9:0] q_sym [QN];
  bit         q_ctl [QN];
  string      q_req [QN];
  int         q_b   [QN];
  int         q_s   [QN];
  int         wr = 0, rd = 0;

  task automatic push(input logic [9:0] s, input bit c, input string req, input int tb, input int ts);
    q_sym[wr % QN] = s; q_ctl[wr % QN] = c; q_req[wr % QN] = req;
    q_b[wr % QN] = tb;  q_s[wr % QN] = ts;
    wr++;
  endtask

  // arithmetic reference encoder (R2, R3, R4)
  int m_disp = 0;
  function automatic logic [9:0] model(input bit de, input logic [1:0] ctl, input logic [7:0] d);
    logic [9:0] r;
    logic [7:0] q;
    int n, n1, bal;
    bit xn, q8;
    if (!de) begin
      m_disp = 0;
      case (ctl)
        2'd0: r = 10'h354;
        2'd1: r = 10'h0AB;
        2'd2: r = 10'h154;
        default: r = 10'h2AB;
      endcase
      return r;
    end
    n = 0;
    for (int i = 0; i < 8; i++) n += d[i];
    xn = (n > 4) || (n == 4 && !d[0]);
    q[0] = d[0];
    for (int i = 1; i < 8; i++) q[i] = xn ? ~(q[i-1] ^ d[i]) : (q[i-1] ^ d[i]);
    q8 = !xn;
    n1 = 0;
    for (int i = 0; i < 8; i++) n1 += q[i];
    bal = 2 * n1 - 8;
    if (m_disp == 0 || bal == 0) begin
      r = {~q8, q8, q8 ? q : ~q};
      m_disp += q8 ? bal : -bal;
    end else if ((m_disp > 0 && bal > 0) || (m_disp < 0 && bal < 0)) begin
      r = {1'b1, q8, ~q};
      m_disp += (q8 ? 2 : 0) - bal;
    end else begin
      r = {1'b0, q8, q};
      m_disp += bal - (q8 ? 0 : 2);
    end
    return r;
  endfunction

  int sc = 0, cyc = 0;
  bit was_en = 1'b0, go = 1'b0, stall = 1'b0;

  always @(posedge clk) begin
    was_en <= bit_en;
    if (bit_en) sc <= sc + 1;
  end

  always @(negedge clk) begin
    cyc++;
    bit_en <= go && (!stall || (cyc % 3 == 0));
    if (cyc > 150000) begin
      chk(1'b0, "R7 watchdog", cyc, 150000);
      finish_run();
    end
  end

  // serial monitor: rebuild symbols LSB first (R6, R7)
  logic [9:0] acc;
  logic [9:0] obs [256][3];
  int bpos = 0, run = 0;
  bit last_bit = 1'b0;

  always @(negedge clk) begin
    if (was_en) begin
      acc[bpos] = ser_out;
      last_bit  = ser_out;
      bpos++;
      if (bpos == 10) begin
        bpos = 0;
        if (rd < wr) begin
          chk(acc == q_sym[rd % QN], q_req[rd % QN], acc, q_sym[rd % QN]);
          if (q_b[rd % QN] >= 0) obs[q_b[rd % QN]][q_s[rd % QN]] = acc;
          if (q_ctl[rd % QN]) run = 0;
          else begin
            run += 2 * $countones(acc) - 10;
            chk(run >= -8 && run <= 8 && (run % 2 == 0), "R6", run, 8);
          end
          rd++;
        end
      end
    end else if (go && stall && sc > 0) begin
      chk(ser_out == last_bit, "R7 hold", ser_out, last_bit);
    end
  end

  task automatic send(input bit de, input logic [1:0] ctl, input logic [7:0] d, input bit rep,
                      input string req, input int tb, input int ts);
    logic [9:0] s;
    pix_de = de; pix_ctl = ctl; pix_data = d; pix_rep = rep;
    do begin
      @(negedge clk); #1;
    end while (!pix_take);
    chk(bit_en && (sc % 10 == 0), "R8", sc, (sc / 10) * 10);
    s = model(de, ctl, d);
    push(s, !de, req, tb, ts);
    if (rep) begin
      s = model(de, ctl, d);
      push(s, !de, "R9", -1, -1);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    chk(ser_out == 1'b0, "R1 ser_out", ser_out, 0);
    chk(pix_take == 1'b0, "R1 pix_take", pix_take, 0);
    push(10'h354, 1'b1, "R1", -1, -1);
    go = 1'b1;

    // R2: each control code, with data lines that must not matter
    for (int c = 0; c < 4; c++) begin
      send(1'b1, 2'd0, 8'h01 + 8'(c), 1'b0, "R4", -1, -1);
      send(1'b0, 2'(c), 8'h5A ^ 8'(c * 37), 1'b0, "R2", -1, -1);
      send(1'b1, 2'd0, 8'hC3, 1'b0, "R2 R4", -1, -1);
    end

    // R3 R4 R5: every byte under positive (0), zero (1) and negative (2) count
    for (int b = 0; b < 256; b++) begin
      for (int s = 0; s < 3; s++) begin
        send(1'b0, 2'd0, 8'h00, 1'b0, "R2", -1, -1);
        if (s == 0) send(1'b1, 2'd0, 8'h01, 1'b0, "R4", -1, -1);
        if (s == 2) send(1'b1, 2'd0, 8'h00, 1'b0, "R4", -1, -1);
        send(1'b1, 2'd0, 8'(b), 1'b0, "R3 R4", b, s);
      end
    end

    // R7: sparse strobe
    stall = 1'b1;
    for (int i = 0; i < 24; i++)
      send(i % 7 != 6, 2'(i), 8'(i * 37 + 5), 1'b0, "R7", -1, -1);
    stall = 1'b0;

    // R9: repeat mixed with single pixels
    for (int i = 0; i < 24; i++)
      send(i != 11, 2'd1, 8'(i * 91 + 3), (i % 3) != 2, "R9", -1, -1);
    send(1'b0, 2'd0, 8'h00, 1'b0, "R2", -1, -1);

    while (rd < wr) @(negedge clk);

    chk(obs[8'h00][0] == 10'h100, "R5 00+", obs[8'h00][0], 10'h100);
    chk(obs[8'h00][1] == 10'h100, "R5 00=", obs[8'h00][1], 10'h100);
    chk(obs[8'h00][2] == 10'h3FF, "R5 00-", obs[8'h00][2], 10'h3FF);
    chk(obs[8'h10][0] == 10'h1F0, "R5 10+", obs[8'h10][0], 10'h1F0);
    chk(obs[8'h10][1] == 10'h1F0, "R5 10=", obs[8'h10][1], 10'h1F0);
    chk(obs[8'h10][2] == 10'h1F0, "R5 10-", obs[8'h10][2], 10'h1F0);
    chk(obs[8'h1F][0] == 10'h2A0, "R5 1F+", obs[8'h1F][0], 10'h2A0);
    chk(obs[8'h1F][1] == 10'h2A0, "R5 1F=", obs[8'h1F][1], 10'h2A0);
    chk(obs[8'h1F][2] == 10'h05F, "R5 1F-", obs[8'h1F][2], 10'h05F);
    chk(obs[8'hFF][0] == 10'h200, "R5 FF+", obs[8'hFF][0], 10'h200);
    chk(obs[8'hFF][1] == 10'h200, "R5 FF=", obs[8'hFF][1], 10'h200);
    chk(obs[8'hFF][2] == 10'h0FF, "R5 FF-", obs[8'hFF][2], 10'h0FF);
    begin
      bit seen [1024];
      int distinct = 0, two = 0, three = 0;
      for (int i = 0; i < 1024; i++) seen[i] = 1'b0;
      for (int b = 0; b < 256; b++) begin
        int eq;
        for (int s = 0; s < 3; s++) begin
          if (!seen[obs[b][s]]) distinct++;
          seen[obs[b][s]] = 1'b1;
        end
        eq = int'(obs[b][0] == obs[b][1]) + int'(obs[b][0] == obs[b][2]) + int'(obs[b][1] == obs[b][2]);
        if (eq == 3) three++;
        else if (eq == 1) two++;
      end
      chk(distinct == 460, "R5 distinct", distinct, 460);
      chk(two == 204, "R5 two-equal", two, 204);
      chk(three == 52, "R5 all-equal", three, 52);
    end
    finish_run();
  end

endmodule